// File: doc/BRIEF.md
# Update-Based Coherence Directory for One Memory Line

This block is the home-node directory controller for a single memory line in a shared-memory system with a fixed number of caches. It keeps the line's coherence state and a presence bit for every cache. It also holds the line's data. Caches send it miss, write, replace and write-back messages. The controller answers on two separate outgoing channels. One is a request channel, for messages that can cause further traffic. The other is a reply channel, for messages that are always consumed.

The protocol updates copies instead of invalidating them. When a cache writes a word of a shared line, the directory writes the word to memory. It then sends a word update to every other cache that holds the line. The writer receives the number of updates that were sent, so it can count the acknowledgements that come back. While the owner's write-back is outstanding, the line is Pending. Misses and writes that arrive during this time are returned to their sender to be retried; they are not queued. The controller takes at most one message per cycle. It lowers its ready output while it sends a burst of updates.

Top module: `dir_update_ctrl`

## Requirements
- R1: After reset the line is Absent with no sharers, every memory word is zero, both output valids are low and in_ready is high.
- R2: A read miss (kind 0) or write miss (kind 1) to an Absent line returns an exclusive reply (kind 10) on the reply channel to the sender. The reply carries the whole line, where word i sits at bits [i*DATA_W +: DATA_W], and for a write miss it already holds the new word. The sender becomes the only sharer and the line becomes Exclusive.
- R3: A read miss to a Shared line returns a shared reply (kind 1) on the request channel to the sender. The reply carries the line and an update count of zero. The sender is added to the sharers.
- R4: A miss to an Exclusive line sends a write-back request to the owner and adds the requester to the sharers. The line becomes Pending. A read miss sends kind 4. A write miss first writes the word to memory and then sends kind 5, which carries the word offset and the word.
- R5: A write miss or a write-word (kind 2) to a Shared line writes the word to memory. The writer then receives a shared reply (kind 1, with the updated line) for a miss, or a write acknowledge (kind 2) for a hit. Either one carries the number of other sharers. After that comes one word update (kind 3) for each other sharer, in ascending cache index. Each update carries the offset and the word, and its peer field names the writer.
- R6: The response to an accepted message is valid in the cycle after the accepting edge. Word updates go out one per cycle after that. in_ready stays low from the accepting edge until the cycle in which the last update is shown. The two channels are never valid in the same cycle.
- R7: While the line is Pending, a read miss is returned to its sender as kind 6, a write miss as kind 7 and a write-word as kind 8, each with its offset and word. The state and the sharer set do not change.
- R8: An update-line message (kind 5, carrying the full line) in the Pending state writes the line to memory and makes the line Shared, with no outgoing message.
- R9: A replace (kind 3) or replace-with-data (kind 4) clears the sender's presence bit and returns a replace acknowledge (kind 9) to the sender. Replace-with-data first writes the whole line to memory. When the last presence bit is cleared outside Pending, the line becomes Absent.
- R10: A returned word update (kind 6, where in_peer names the writer) is re-sent as kind 3 to the sender with the current memory word if the sender still holds the line. Otherwise an update acknowledge (kind 11) goes to the writer on the reply channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller can take a message |
| in_kind | input | 4 | Incoming message kind |
| in_src | input | SRC_W | Sending cache |
| in_peer | input | SRC_W | Writer named by a returned update |
| in_off | input | OFF_W | Word offset |
| in_word | input | DATA_W | Word data |
| in_line | input | LINE_W | Full line data |
| rq_valid | output | 1 | Request-channel message valid |
| rq_kind | output | 4 | Request-channel message kind |
| rq_dst | output | SRC_W | Destination cache |
| rq_peer | output | SRC_W | Writer to acknowledge |
| rq_off | output | OFF_W | Word offset |
| rq_word | output | DATA_W | Word data |
| rq_line | output | LINE_W | Line data |
| rq_count | output | CNT_W | Number of updates sent |
| rp_valid | output | 1 | Reply-channel message valid |
| rp_kind | output | 4 | Reply-channel message kind |
| rp_dst | output | SRC_W | Destination cache |
| rp_line | output | LINE_W | Line data |

## Verification
The update fan-out is tried with two patterns. The first has a single other sharer, so it checks that the writer is never targeted and that the count is one. The second has three other sharers around the writer, so it checks the ascending order, the per-cycle pacing and the timing of ready. Write-backs are tried both with and without a carried word, which shows whether memory is updated before the owner is asked. Requests that arrive in the Pending window are followed by later requests from the same caches, which shows that bounced requesters were never added to the sharers. Returned updates come both from a cache that holds the line and from one that does not, which separates the re-send path from the direct acknowledge.

// File: rtl/dir_upd_pkg.sv
package dir_upd_pkg;

  typedef enum logic [1:0] {
    ST_ABSENT = 2'd0,
    ST_SHARED = 2'd1,
    ST_EXCL   = 2'd2,
    ST_PEND   = 2'd3
  } line_state_e;

  // incoming kinds
  localparam logic [3:0] K_RD_MISS      = 4'd0;
  localparam logic [3:0] K_WR_MISS      = 4'd1;
  localparam logic [3:0] K_WR_WORD      = 4'd2;
  localparam logic [3:0] K_REPLACE      = 4'd3;
  localparam logic [3:0] K_REPLACE_DATA = 4'd4;
  localparam logic [3:0] K_LINE_UPD     = 4'd5;
  localparam logic [3:0] K_UPD_BOUNCE   = 4'd6;

  // outgoing kinds
  localparam logic [3:0] O_SH_REPLY  = 4'd1;
  localparam logic [3:0] O_WR_ACK    = 4'd2;
  localparam logic [3:0] O_UPD_WORD  = 4'd3;
  localparam logic [3:0] O_WB        = 4'd4;
  localparam logic [3:0] O_WB_UPD    = 4'd5;
  localparam logic [3:0] O_RM_BOUNCE = 4'd6;
  localparam logic [3:0] O_WM_BOUNCE = 4'd7;
  localparam logic [3:0] O_WW_BOUNCE = 4'd8;
  localparam logic [3:0] O_REPL_ACK  = 4'd9;
  localparam logic [3:0] O_EX_REPLY  = 4'd10;
  localparam logic [3:0] O_UPD_ACK   = 4'd11;

endpackage

// File: rtl/dir_presence.sv
module dir_presence #(
  parameter int N     = 4,
  parameter int SRC_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] idx,
  output logic [N-1:0]     vec,
  output logic [N-1:0]     others,
  output logic [CNT_W-1:0] others_cnt,
  output logic [SRC_W-1:0] owner,
  output logic             hit,
  output logic             rest_empty
);

  logic [N-1:0] sel;

  always_comb begin
    sel      = '0;
    sel[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         vec      <= '0;
    else if (set_en) vec[idx] <= 1'b1;
    else if (clr_en) vec[idx] <= 1'b0;
  end

  assign others     = vec & ~sel;
  assign hit        = vec[idx];
  assign rest_empty = (others == '0);

  always_comb begin
    others_cnt = '0;
    for (int i = 0; i < N; i++) others_cnt = others_cnt + CNT_W'(others[i]);
  end

  always_comb begin
    owner = '0;
    for (int i = N - 1; i >= 0; i--) if (vec[i]) owner = SRC_W'(i);
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en)); // R9

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !vec[$past(idx)]); // R9

endmodule

// File: rtl/dir_line_store.sv
module dir_line_store #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 2,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_word,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              we_line,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_word,
  output logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] mrg_line
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we_line) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= wr_line[i*DATA_W +: DATA_W];
    end else if (we_word) begin
      mem[wr_off] <= wr_word;
    end
  end

  assign rd_word = mem[rd_off];

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign line[g*DATA_W +: DATA_W]     = mem[g];
    assign mrg_line[g*DATA_W +: DATA_W] = (wr_off == OFF_W'(g)) ? wr_word : mem[g];
  end

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!we_word && !we_line) |=> $stable(line)); // R7

  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we_word && !we_line) |=> mem[$past(wr_off)] == $past(wr_word)); // R5

endmodule

// File: rtl/dir_fanout.sv
module dir_fanout #(
  parameter int N     = 4,
  parameter int SRC_W = 2,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N-1:0]     load_mask,
  input  logic [SRC_W-1:0] load_writer,
  input  logic [OFF_W-1:0] load_off,
  output logic             busy,
  output logic [SRC_W-1:0] dst,
  output logic [SRC_W-1:0] writer,
  output logic [OFF_W-1:0] off
);

  logic [N-1:0] mask;
  logic [N-1:0] lowbit;

  assign lowbit = mask & (~mask + {{(N-1){1'b0}}, 1'b1});
  assign busy   = (mask != '0);

  always_comb begin
    dst = '0;
    for (int i = N - 1; i >= 0; i--) if (mask[i]) dst = SRC_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      writer <= '0;
      off    <= '0;
    end else if (load) begin
      mask   <= load_mask;
      writer <= load_writer;
      off    <= load_off;
    end else if (busy) begin
      mask   <= mask & ~lowbit;
    end
  end

  AST_FANOUT_DRAINS: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(mask) + 1) == $past($countones(mask))); // R6

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load); // R6

endmodule

// File: rtl/dir_update_ctrl.sv
module dir_update_ctrl
  import dir_upd_pkg::*;
#(
  parameter int N_CACHES   = 4,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 16,
  localparam int SRC_W  = (N_CACHES > 1) ? $clog2(N_CACHES) : 1,
  localparam int CNT_W  = $clog2(N_CACHES + 1),
  localparam int OFF_W  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int LINE_W = LINE_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_kind,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [SRC_W-1:0]  in_peer,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [DATA_W-1:0] in_word,
  input  logic [LINE_W-1:0] in_line,
  output logic              rq_valid,
  output logic [3:0]        rq_kind,
  output logic [SRC_W-1:0]  rq_dst,
  output logic [SRC_W-1:0]  rq_peer,
  output logic [OFF_W-1:0]  rq_off,
  output logic [DATA_W-1:0] rq_word,
  output logic [LINE_W-1:0] rq_line,
  output logic [CNT_W-1:0]  rq_count,
  output logic              rp_valid,
  output logic [3:0]        rp_kind,
  output logic [SRC_W-1:0]  rp_dst,
  output logic [LINE_W-1:0] rp_line
);

  line_state_e st, st_n;

  logic set_en, clr_en, we_word, we_line, fo_load;
  logic [N_CACHES-1:0] sh_vec, sh_others;
  logic [CNT_W-1:0]    sh_cnt;
  logic [SRC_W-1:0]    sh_owner;
  logic                sh_hit, sh_rest_empty;

  logic [OFF_W-1:0]  rd_off;
  logic [DATA_W-1:0] rd_word;
  logic [LINE_W-1:0] cur_line, mrg_line;

  logic             fo_busy;
  logic [SRC_W-1:0] fo_dst, fo_writer;
  logic [OFF_W-1:0] fo_off;

  logic              rq_v_n, rp_v_n;
  logic [3:0]        rq_k_n, rp_k_n;
  logic [SRC_W-1:0]  rq_dst_n, rq_peer_n, rp_dst_n;
  logic [OFF_W-1:0]  rq_off_n;
  logic [DATA_W-1:0] rq_word_n;
  logic [LINE_W-1:0] rq_line_n, rp_line_n;
  logic [CNT_W-1:0]  rq_cnt_n;

  dir_presence #(.N(N_CACHES), .SRC_W(SRC_W), .CNT_W(CNT_W)) i_presence (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en), .idx(in_src),
    .vec(sh_vec), .others(sh_others), .others_cnt(sh_cnt), .owner(sh_owner),
    .hit(sh_hit), .rest_empty(sh_rest_empty)
  );

  dir_line_store #(.WORDS(LINE_WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_store (
    .clk(clk), .rst(rst), .we_word(we_word), .wr_off(in_off), .wr_word(in_word),
    .we_line(we_line), .wr_line(in_line), .rd_off(rd_off), .rd_word(rd_word),
    .line(cur_line), .mrg_line(mrg_line)
  );

  dir_fanout #(.N(N_CACHES), .SRC_W(SRC_W), .OFF_W(OFF_W)) i_fanout (
    .clk(clk), .rst(rst), .load(fo_load), .load_mask(sh_others),
    .load_writer(in_src), .load_off(in_off), .busy(fo_busy),
    .dst(fo_dst), .writer(fo_writer), .off(fo_off)
  );

  assign in_ready = !fo_busy;
  assign rd_off   = fo_busy ? fo_off : in_off;

  always_comb begin
    st_n = st;
    set_en = 1'b0; clr_en = 1'b0; we_word = 1'b0; we_line = 1'b0; fo_load = 1'b0;
    rq_v_n = 1'b0; rq_k_n = rq_kind; rq_dst_n = rq_dst; rq_peer_n = rq_peer;
    rq_off_n = rq_off; rq_word_n = rq_word; rq_line_n = rq_line; rq_cnt_n = rq_count;
    rp_v_n = 1'b0; rp_k_n = rp_kind; rp_dst_n = rp_dst; rp_line_n = rp_line;

    if (fo_busy) begin
      rq_v_n    = 1'b1;
      rq_k_n    = O_UPD_WORD;
      rq_dst_n  = fo_dst;
      rq_peer_n = fo_writer;
      rq_off_n  = fo_off;
      rq_word_n = rd_word;
      rq_cnt_n  = '0;
    end else if (in_valid) begin
      rq_dst_n  = in_src;
      rq_peer_n = in_peer;
      rq_off_n  = in_off;
      rq_word_n = in_word;
      rq_line_n = cur_line;
      rq_cnt_n  = '0;
      rp_dst_n  = in_src;
      rp_line_n = cur_line;
      case (in_kind)
        K_RD_MISS: begin
          case (st)
            ST_ABSENT: begin
              set_en = 1'b1; st_n = ST_EXCL;
              rp_v_n = 1'b1; rp_k_n = O_EX_REPLY;
            end
            ST_SHARED: begin
              set_en = 1'b1;
              rq_v_n = 1'b1; rq_k_n = O_SH_REPLY;
            end
            ST_EXCL: begin
              set_en = 1'b1; st_n = ST_PEND;
              rq_v_n = 1'b1; rq_k_n = O_WB; rq_dst_n = sh_owner;
            end
            default: begin
              rq_v_n = 1'b1; rq_k_n = O_RM_BOUNCE;
            end
          endcase
        end
        K_WR_MISS: begin
          case (st)
            ST_ABSENT: begin
              set_en = 1'b1; we_word = 1'b1; st_n = ST_EXCL;
              rp_v_n = 1'b1; rp_k_n = O_EX_REPLY; rp_line_n = mrg_line;
            end
            ST_SHARED: begin
              set_en = 1'b1; we_word = 1'b1; fo_load = 1'b1;
              rq_v_n = 1'b1; rq_k_n = O_SH_REPLY; rq_line_n = mrg_line;
              rq_cnt_n = sh_cnt;
            end
            ST_EXCL: begin
              set_en = 1'b1; we_word = 1'b1; st_n = ST_PEND;
              rq_v_n = 1'b1; rq_k_n = O_WB_UPD; rq_dst_n = sh_owner;
            end
            default: begin
              rq_v_n = 1'b1; rq_k_n = O_WM_BOUNCE;
            end
          endcase
        end
        K_WR_WORD: begin
          if (st == ST_SHARED) begin
            we_word = 1'b1; fo_load = 1'b1;
            rq_v_n = 1'b1; rq_k_n = O_WR_ACK; rq_cnt_n = sh_cnt;
          end else if (st == ST_PEND) begin
            rq_v_n = 1'b1; rq_k_n = O_WW_BOUNCE;
          end
        end
        K_REPLACE, K_REPLACE_DATA: begin
          clr_en  = 1'b1;
          we_line = (in_kind == K_REPLACE_DATA);
          rq_v_n  = 1'b1; rq_k_n = O_REPL_ACK;
          if (st != ST_PEND && sh_rest_empty) st_n = ST_ABSENT;
        end
        K_LINE_UPD: begin
          if (st == ST_PEND) begin
            we_line = 1'b1; st_n = ST_SHARED;
          end
        end
        K_UPD_BOUNCE: begin
          if (sh_hit) begin
            rq_v_n = 1'b1; rq_k_n = O_UPD_WORD; rq_word_n = rd_word;
          end else begin
            rp_v_n = 1'b1; rp_k_n = O_UPD_ACK; rp_dst_n = in_peer;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_ABSENT;
      rq_valid <= 1'b0; rq_kind <= '0; rq_dst <= '0; rq_peer <= '0;
      rq_off   <= '0;   rq_word <= '0; rq_line <= '0; rq_count <= '0;
      rp_valid <= 1'b0; rp_kind <= '0; rp_dst <= '0; rp_line <= '0;
    end else begin
      st       <= st_n;
      rq_valid <= rq_v_n; rq_kind <= rq_k_n; rq_dst <= rq_dst_n; rq_peer <= rq_peer_n;
      rq_off   <= rq_off_n; rq_word <= rq_word_n; rq_line <= rq_line_n; rq_count <= rq_cnt_n;
      rp_valid <= rp_v_n; rp_kind <= rp_k_n; rp_dst <= rp_dst_n; rp_line <= rp_line_n;
    end
  end

  AST_ABSENT_NO_SHARERS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ABSENT) |-> (sh_vec == '0)); // R9

  AST_EXCL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXCL) |-> ($countones(sh_vec) == 1)); // R2

  AST_PEND_HAS_SHARER: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PEND) |-> (sh_vec != '0)); // R4

  AST_UPD_TO_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && rq_kind == O_UPD_WORD) |-> sh_vec[rq_dst]); // R5

  AST_NO_SELF_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && rq_kind == O_UPD_WORD) |-> (rq_dst != rq_peer)); // R5

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    !(rq_valid && rp_valid)); // R6

endmodule

// File: tb/test_dir_update_ctrl.sv
`timescale 1ns/1ps
module test_dir_update_ctrl;

  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]  kind;
    logic [1:0]  src;
    logic [1:0]  peer;
    logic [1:0]  off;
    logic [15:0] word;
    logic [63:0] line;
    logic [1:0]  ch;     // 0 none, 1 request channel, 2 reply channel
    logic [3:0]  ekind;
    logic [1:0]  edst;
    logic [2:0]  ecnt;
    logic        cdat;
    logic [15:0] edat;
    logic [3:0]  req;
  } row_t;

  localparam logic [63:0] LA = {16'hA003, 16'h1111, 16'hA001, 16'hA000};
  localparam logic [63:0] LB = {16'hB003, 16'hB002, 16'hB001, 16'hB000};
  localparam logic [63:0] LC = {16'hC003, 16'hC002, 16'hC001, 16'hC000};

  localparam int NV = 17;
  localparam row_t TBL [NV] = '{
    '{4'd0, 2'd0, 2'd0, 2'd0, 16'h0,    64'h0, 2'd2, 4'd10, 2'd0, 3'd0, 1'b1, 16'h0000, 4'd2},  // R2 read miss absent
    '{4'd1, 2'd1, 2'd0, 2'd2, 16'h1111, 64'h0, 2'd1, 4'd5,  2'd0, 3'd0, 1'b1, 16'h1111, 4'd4},  // R4 write miss excl
    '{4'd0, 2'd2, 2'd0, 2'd0, 16'h0,    64'h0, 2'd1, 4'd6,  2'd2, 3'd0, 1'b0, 16'h0,    4'd7},  // R7
    '{4'd2, 2'd1, 2'd0, 2'd1, 16'h2222, 64'h0, 2'd1, 4'd8,  2'd1, 3'd0, 1'b1, 16'h2222, 4'd7},  // R7
    '{4'd1, 2'd3, 2'd0, 2'd3, 16'h3333, 64'h0, 2'd1, 4'd7,  2'd3, 3'd0, 1'b1, 16'h3333, 4'd7},  // R7
    '{4'd5, 2'd0, 2'd0, 2'd0, 16'h0,    LA,    2'd0, 4'd0,  2'd0, 3'd0, 1'b0, 16'h0,    4'd8},  // R8
    '{4'd0, 2'd2, 2'd0, 2'd1, 16'h0,    64'h0, 2'd1, 4'd1,  2'd2, 3'd0, 1'b1, 16'hA001, 4'd3},  // R3 R8
    '{4'd6, 2'd3, 2'd1, 2'd1, 16'h0,    64'h0, 2'd2, 4'd11, 2'd1, 3'd0, 1'b0, 16'h0,    4'd10}, // R10 R7
    '{4'd6, 2'd2, 2'd0, 2'd2, 16'h0,    64'h0, 2'd1, 4'd3,  2'd2, 3'd0, 1'b1, 16'h1111, 4'd10}, // R10
    '{4'd3, 2'd2, 2'd0, 2'd0, 16'h0,    64'h0, 2'd1, 4'd9,  2'd2, 3'd0, 1'b0, 16'h0,    4'd9},  // R9
    '{4'd4, 2'd1, 2'd0, 2'd0, 16'h0,    LB,    2'd1, 4'd9,  2'd1, 3'd0, 1'b0, 16'h0,    4'd9},  // R9
    '{4'd0, 2'd3, 2'd0, 2'd3, 16'h0,    64'h0, 2'd1, 4'd1,  2'd3, 3'd0, 1'b1, 16'hB003, 4'd9},  // R9 R3
    '{4'd3, 2'd0, 2'd0, 2'd0, 16'h0,    64'h0, 2'd1, 4'd9,  2'd0, 3'd0, 1'b0, 16'h0,    4'd9},  // R9
    '{4'd3, 2'd3, 2'd0, 2'd0, 16'h0,    64'h0, 2'd1, 4'd9,  2'd3, 3'd0, 1'b0, 16'h0,    4'd9},  // R9
    '{4'd0, 2'd1, 2'd0, 2'd2, 16'h0,    64'h0, 2'd2, 4'd10, 2'd1, 3'd0, 1'b1, 16'hB002, 4'd9},  // R9 R2
    '{4'd0, 2'd2, 2'd0, 2'd0, 16'h0,    64'h0, 2'd1, 4'd4,  2'd1, 3'd0, 1'b0, 16'h0,    4'd4},  // R4
    '{4'd5, 2'd1, 2'd0, 2'd0, 16'h0,    LC,    2'd0, 4'd0,  2'd0, 3'd0, 1'b0, 16'h0,    4'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0]  in_kind = '0;
  logic [1:0]  in_src = '0, in_peer = '0, in_off = '0;
  logic [15:0] in_word = '0;
  logic [63:0] in_line = '0;
  logic rq_valid, rp_valid;
  logic [3:0]  rq_kind, rp_kind;
  logic [1:0]  rq_dst, rq_peer, rq_off, rp_dst;
  logic [15:0] rq_word;
  logic [63:0] rq_line, rp_line;
  logic [2:0]  rq_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dir_update_ctrl i_dir_update_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_src(in_src), .in_peer(in_peer), .in_off(in_off),
    .in_word(in_word), .in_line(in_line),
    .rq_valid(rq_valid), .rq_kind(rq_kind), .rq_dst(rq_dst), .rq_peer(rq_peer),
    .rq_off(rq_off), .rq_word(rq_word), .rq_line(rq_line), .rq_count(rq_count),
    .rp_valid(rp_valid), .rp_kind(rp_kind), .rp_dst(rp_dst), .rp_line(rp_line)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one message, return at the negedge after the accepting edge
  task automatic send(input logic [3:0] k, input logic [1:0] s, input logic [1:0] p,
                      input logic [1:0] o, input logic [15:0] w, input logic [63:0] l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_kind = k; in_src = s; in_peer = p; in_off = o; in_word = w; in_line = l;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_upd(input string tag, input logic [1:0] dst, input logic [1:0] peer,
                         input logic [15:0] w);
    chk({tag, " upd valid"}, 64'(rq_valid), 64'd1);
    chk({tag, " upd kind"},  64'(rq_kind), 64'd3);
    chk({tag, " upd dst"},   64'(rq_dst), 64'(dst));
    chk({tag, " upd peer"},  64'(rq_peer), 64'(peer));
    chk({tag, " upd word"},  64'(rq_word), 64'(w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 rq_valid", 64'(rq_valid), 64'd0);
    chk("R1 rp_valid", 64'(rp_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      row_t v;
      string tg;
      v  = TBL[i];
      tg = $sformatf("R%0d row%0d", v.req, i);
      send(v.kind, v.src, v.peer, v.off, v.word, v.line);
      chk({tg, " rq_valid"}, 64'(rq_valid), 64'(v.ch == 2'd1));
      chk({tg, " rp_valid"}, 64'(rp_valid), 64'(v.ch == 2'd2));
      if (v.ch == 2'd1) begin
        chk({tg, " kind"},  64'(rq_kind), 64'(v.ekind));
        chk({tg, " dst"},   64'(rq_dst), 64'(v.edst));
        chk({tg, " count"}, 64'(rq_count), 64'(v.ecnt));
        if (v.cdat) begin
          if (v.ekind == 4'd1) chk({tg, " line word"}, 64'(rq_line[v.off*DW +: DW]), 64'(v.edat));
          else                 chk({tg, " word"}, 64'(rq_word), 64'(v.edat));
        end
      end else if (v.ch == 2'd2) begin
        chk({tg, " kind"}, 64'(rp_kind), 64'(v.ekind));
        chk({tg, " dst"},  64'(rp_dst), 64'(v.edst));
        if (v.cdat) chk({tg, " line word"}, 64'(rp_line[v.off*DW +: DW]), 64'(v.edat));
      end
    end

    // R5 R6: write-word with one other sharer {1,2}, writer 1
    send(4'd2, 2'd1, 2'd0, 2'd0, 16'hD00D, 64'h0);
    chk("R5 wa kind", 64'(rq_kind), 64'd2);
    chk("R5 wa dst", 64'(rq_dst), 64'd1);
    chk("R5 wa count", 64'(rq_count), 64'd1);
    chk("R6 ready low at ack", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk_upd("R5 single", 2'd2, 2'd1, 16'hD00D);
    chk("R6 ready back", 64'(in_ready), 64'd1);

    // R3: add caches 0 and 3, memory shows the written word
    send(4'd0, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0);
    chk("R3 sr kind", 64'(rq_kind), 64'd1);
    chk("R5 mem word", 64'(rq_line[0 +: DW]), 64'hD00D);
    send(4'd0, 2'd3, 2'd0, 2'd1, 16'h0, 64'h0);
    chk("R3 sr count", 64'(rq_count), 64'd0);
    chk("R3 sr word", 64'(rq_line[DW +: DW]), 64'hC001);

    // R5 R6: write miss by cache 2 with three other sharers
    send(4'd1, 2'd2, 2'd0, 2'd3, 16'hE00E, 64'h0);
    chk("R5 sr kind", 64'(rq_kind), 64'd1);
    chk("R5 sr dst", 64'(rq_dst), 64'd2);
    chk("R5 sr count", 64'(rq_count), 64'd3);
    chk("R5 sr merged", 64'(rq_line[3*DW +: DW]), 64'hE00E);
    chk("R6 ready low 0", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk_upd("R5 first", 2'd0, 2'd2, 16'hE00E);
    chk("R6 ready low 1", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk_upd("R5 second", 2'd1, 2'd2, 16'hE00E);
    chk("R6 ready low 2", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk_upd("R5 third", 2'd3, 2'd2, 16'hE00E);
    chk("R6 ready high 3", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk("R6 burst ends", 64'(rq_valid), 64'd0);

    // R1: reset in mid-run clears state and memory
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rq idle", 64'(rq_valid), 64'd0);
    chk("R1 ready", 64'(in_ready), 64'd1);
    send(4'd0, 2'd0, 2'd0, 2'd3, 16'h0, 64'h0);
    chk("R1 absent after reset", 64'(rp_kind), 64'd10);
    chk("R1 memory cleared", 64'(rp_line), 64'h0);

    // R2 write miss to absent
    send(4'd3, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0);
    chk("R9 ack", 64'(rq_kind), 64'd9);
    send(4'd1, 2'd2, 2'd0, 2'd1, 16'h5A5A, 64'h0);
    chk("R2 wm valid", 64'(rp_valid), 64'd1);
    chk("R2 wm kind", 64'(rp_kind), 64'd10);
    chk("R2 wm dst", 64'(rp_dst), 64'd2);
    chk("R2 wm word", 64'(rp_line[DW +: DW]), 64'h5A5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule